// File: doc/BRIEF.md
# Demand and Burst Conversion Sequencer

This block sits between a byte-wide serial port and a three-input, 10-bit analog-to-digital converter. It is the supervisory controller. The host sends 8-bit command bytes. Each command addresses one input and sets that input's reference selection, its gain selection and its acquisition style. The style is either on-request (demand) or free-running (burst). Each input keeps its own settings, so a command only touches the input it names.

A demand command starts exactly one conversion. The host then receives the command byte echoed back, followed by two data bytes that carry the result and the input number. Once one or more inputs are in burst mode, conversions continue without further commands. The block starts a new conversion only after the host has read out the previous result, and it visits the burst inputs in ascending order, wrapping around. Because both data bytes name their input, the host can sort an interleaved stream.

The converter is driven through a start pulse carrying the input number and the selected reference and gain. It answers with a done pulse carrying the result. When no byte is ready, the serial side is told so through a valid flag.

Top module: `adcseq_top`

## Requirements
- R1: After reset, tx_valid is 0, conv_start is 0, and every input is in demand mode, so nothing happens until a command arrives.
- R2: A received byte whose bits 7:6 are not 11, or whose bits 5:4 are 11, is ignored: no echo, no conversion, and no change to any input's settings or mode.
- R3: A legal command byte (bits 7:6 = 11, bits 5:4 = input 0..2, bit 1 = 1 for demand) makes its exact value available on tx_byte in the cycle after it is received. A demand command also causes one conversion on input bits 5:4.
- R4: conv_start is a single-cycle pulse, and no new pulse is issued until conv_done has returned for the previous one.
- R5: The first data byte of a result is {2'b10, input[1:0], result[9:6]}.
- R6: The second data byte is {1'b0, result[5:0], 1'b0}. It is presented immediately after its first data byte is read, and no echo is ever placed between the two.
- R7: Every input stores its own reference bit (command bit 3) and gain bit (command bit 0). conv_ref and conv_gain show the stored bits of the input being converted, from its start pulse until the next start pulse.
- R8: Burst inputs (command bit 1 = 0) are converted in ascending input order. The order wraps from the highest enabled input back to the lowest, continuing from the last burst input converted.
- R9: A new conversion starts only after both data bytes of the previous result have been read. Without host reads, a burst stream stalls after one buffered result.
- R10: When no input is in burst mode and no demand request is waiting, no conversion starts and tx_valid stays 0 once the output has been drained.
- R11: A demand command sent to a burst input returns that input to demand mode. A waiting demand request is converted before the next burst input.
- R12: A pending echo is presented ahead of a buffered result whose first data byte has not yet been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received command byte |
| rd_req | input | 1 | Host consumes tx_byte this cycle (ignored when tx_valid is 0) |
| tx_valid | output | 1 | tx_byte holds a byte ready to send |
| tx_byte | output | 8 | Next byte for the host |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 2 | Input number being converted |
| conv_ref | output | 1 | Reference selection for the current conversion (1 = supply) |
| conv_gain | output | 1 | Gain selection for the current conversion (1 = unity, 0 = half) |
| conv_done | input | 1 | One-cycle strobe: conversion finished |
| conv_result | input | 10 | Conversion result, valid with conv_done |

## Verification
The bench mixes commands into a partly read packet. It expects the second data byte ahead of the newer echo, because a design that let the echo in would split a result. It enables a second burst input while a conversion is in flight, and checks that the rotation continues from the last input converted rather than restarting at input 0. It also stops reading for a long stretch and counts start pulses; a design that paced bursts by time instead of by reads would keep converting. Finally, it sends a demand command to a burst input with a result still buffered, and expects the demand conversion to win over the rotation. After that the input must go quiet; a design that left the burst bit set would never go idle.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int BYTE_W = 8;
    localparam int RES_W  = 10;
    localparam int CH_W   = 2;

    typedef logic [CH_W-1:0]  chan_t;
    typedef logic [RES_W-1:0] res_t;

    typedef struct packed {
        logic  valid;
        chan_t chan;
        logic  ref_sup;
        logic  unity_gain;
        logic  demand;
    } cmd_t;

    typedef enum logic [1:0] {
        BUF_EMPTY = 2'd0,
        BUF_HI    = 2'd1,
        BUF_LO    = 2'd2
    } buf_t;

    function automatic logic [BYTE_W-1:0] fmt_hi(chan_t c, res_t r);
        return {2'b10, c, r[9:6]};
    endfunction

    function automatic logic [BYTE_W-1:0] fmt_lo(res_t r);
        return {1'b0, r[5:0], 1'b0};
    endfunction

endpackage

// File: rtl/adcseq_cmd_dec.sv
module adcseq_cmd_dec
    import adcseq_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output cmd_t              cmd
);
    localparam chan_t MAX_CH = chan_t'(NUM_CH - 1);

    logic legal;

    always_comb begin
        legal          = (rx_byte[7:6] == 2'b11) && (rx_byte[5:4] <= MAX_CH);
        cmd.valid      = rx_valid && legal;
        cmd.chan       = rx_byte[5:4];
        cmd.ref_sup    = rx_byte[3];
        cmd.demand     = rx_byte[1];
        cmd.unity_gain = rx_byte[0];
    end

endmodule

// File: rtl/adcseq_cfg_bank.sv
module adcseq_cfg_bank
    import adcseq_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    output logic [NUM_CH-1:0] demand_vec,
    output logic [NUM_CH-1:0] ref_vec,
    output logic [NUM_CH-1:0] gain_vec
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic dem_q, ref_q, gain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                dem_q  <= 1'b1;
                ref_q  <= 1'b1;
                gain_q <= 1'b1;
            end else if (cmd.valid && (cmd.chan == chan_t'(i))) begin
                dem_q  <= cmd.demand;
                ref_q  <= cmd.ref_sup;
                gain_q <= cmd.unity_gain;
            end
        end

        assign demand_vec[i] = dem_q;
        assign ref_vec[i]    = ref_q;
        assign gain_vec[i]   = gain_q;
    end

endmodule

// File: rtl/adcseq_rr_pick.sv
module adcseq_rr_pick
    import adcseq_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [NUM_CH-1:0] mask,
    input  chan_t             last,
    output logic              any,
    output chan_t             next
);

    always_comb begin
        any  = |mask;
        next = last;
        // walk offsets from far to near so the nearest enabled input wins
        for (int off = NUM_CH; off >= 1; off--) begin
            int idx;
            idx = (int'(last) + off) % NUM_CH;
            if (mask[idx]) next = chan_t'(idx);
        end
    end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rd_req,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       conv_start,
    output logic [1:0] conv_chan,
    output logic       conv_ref,
    output logic       conv_gain,
    input  logic       conv_done,
    input  logic [9:0] conv_result
);
    localparam chan_t LAST_INIT = chan_t'(NUM_CH - 1);

    cmd_t              cmd;
    logic [NUM_CH-1:0] demand_vec, ref_vec, gain_vec;
    logic              rr_any;
    chan_t             rr_next;

    logic              echo_pend;
    logic [7:0]        echo_byte;
    logic              dmd_pend;
    chan_t             dmd_chan;
    logic              busy;
    chan_t             cur_chan;
    chan_t             last_chan;
    buf_t              bstate;
    res_t              res_q;
    chan_t             res_chan;
    logic              start_q, ref_q, gain_q;
    logic              pop;

    adcseq_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .cmd      (cmd)
    );

    adcseq_cfg_bank #(.NUM_CH(NUM_CH)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .demand_vec (demand_vec),
        .ref_vec    (ref_vec),
        .gain_vec   (gain_vec)
    );

    adcseq_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
        .mask (~demand_vec),
        .last (last_chan),
        .any  (rr_any),
        .next (rr_next)
    );

    // output selection: a started packet finishes first, then echo, then data
    always_comb begin
        tx_valid = 1'b0;
        tx_byte  = 8'h00;
        if (bstate == BUF_LO) begin
            tx_valid = 1'b1;
            tx_byte  = fmt_lo(res_q);
        end else if (echo_pend) begin
            tx_valid = 1'b1;
            tx_byte  = echo_byte;
        end else if (bstate == BUF_HI) begin
            tx_valid = 1'b1;
            tx_byte  = fmt_hi(res_chan, res_q);
        end
    end

    assign pop = rd_req && tx_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            echo_pend <= 1'b0;
            echo_byte <= '0;
            dmd_pend  <= 1'b0;
            dmd_chan  <= '0;
            busy      <= 1'b0;
            cur_chan  <= '0;
            last_chan <= LAST_INIT;
            bstate    <= BUF_EMPTY;
            res_q     <= '0;
            res_chan  <= '0;
            start_q   <= 1'b0;
            ref_q     <= 1'b0;
            gain_q    <= 1'b0;
        end else begin
            start_q <= 1'b0;

            if (pop) begin
                if (bstate == BUF_LO)      bstate    <= BUF_EMPTY;
                else if (echo_pend)        echo_pend <= 1'b0;
                else if (bstate == BUF_HI) bstate    <= BUF_LO;
            end

            if (busy) begin
                if (conv_done) begin
                    busy     <= 1'b0;
                    res_q    <= conv_result;
                    res_chan <= cur_chan;
                    bstate   <= BUF_HI;
                end
            end else if (bstate == BUF_EMPTY) begin
                if (dmd_pend) begin
                    busy     <= 1'b1;
                    start_q  <= 1'b1;
                    cur_chan <= dmd_chan;
                    ref_q    <= ref_vec[dmd_chan];
                    gain_q   <= gain_vec[dmd_chan];
                    dmd_pend <= 1'b0;
                end else if (rr_any) begin
                    busy      <= 1'b1;
                    start_q   <= 1'b1;
                    cur_chan  <= rr_next;
                    last_chan <= rr_next;
                    ref_q     <= ref_vec[rr_next];
                    gain_q    <= gain_vec[rr_next];
                end
            end

            // a new command overrides the request just launched
            if (cmd.valid) begin
                echo_pend <= 1'b1;
                echo_byte <= rx_byte;
                if (cmd.demand) begin
                    dmd_pend <= 1'b1;
                    dmd_chan <= cmd.chan;
                end
            end
        end
    end

    assign conv_start = start_q;
    assign conv_chan  = cur_chan;
    assign conv_ref   = ref_q;
    assign conv_gain  = gain_q;

endmodule

// File: rtl/adcseq_top_chk.sv
module adcseq_top_chk #(
    parameter int NUM_CH = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       rd_req,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       conv_start,
    input logic [1:0] conv_chan,
    input logic       conv_ref,
    input logic       conv_gain,
    input logic       conv_done,
    input logic [9:0] conv_result
);
    localparam logic [1:0] MAX_CH = 2'(NUM_CH - 1);

    logic outst;
    logic bad_byte;
    logic good_byte;

    assign bad_byte  = rx_valid && ((rx_byte[7:6] != 2'b11) || (rx_byte[5:4] > MAX_CH));
    assign good_byte = rx_valid && !bad_byte;

    always_ff @(posedge clk) begin
        if (rst)             outst <= 1'b0;
        else if (conv_start) outst <= 1'b1;
        else if (conv_done)  outst <= 1'b0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!tx_valid && !conv_start));

    assert_ignore_bad_R2: assert property (@(posedge clk) disable iff (rst)
        (bad_byte && !tx_valid && !outst && !conv_start) |=> !tx_valid);

    assert_echo_next_R3: assert property (@(posedge clk) disable iff (rst)
        good_byte |=> tx_valid);

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !outst);

    assert_hi_chan_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_byte[7:6] == 2'b10) |-> (tx_byte[5:4] <= MAX_CH));

    assert_lo_pad_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_byte[7]) |-> !tx_byte[0]);

    assert_lo_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && rd_req && tx_byte[7:6] == 2'b10) |=> (tx_valid && !tx_byte[7]));

    assert_lo_held_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_byte[7] && !rd_req) |=> (tx_valid && $stable(tx_byte)));

    assert_sel_held_R7: assert property (@(posedge clk) disable iff (rst)
        (outst && !conv_start) |=> ($stable(conv_ref) && $stable(conv_gain) && $stable(conv_chan)));

    assert_start_empty_R9: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !(tx_valid && tx_byte[7:6] != 2'b11));

    assert_valid_chan_R8: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (conv_chan <= MAX_CH));

    logic unused_ok;
    assign unused_ok = ^conv_result;

endmodule

bind adcseq_top adcseq_top_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .rd_req      (rd_req),
    .tx_valid    (tx_valid),
    .tx_byte     (tx_byte),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan),
    .conv_ref    (conv_ref),
    .conv_gain   (conv_gain),
    .conv_done   (conv_done),
    .conv_result (conv_result)
);

// File: tb/adcseq_top_test.sv
`timescale 1ns/1ps
module adcseq_top_test;

    localparam int LAT = 25;

    typedef struct packed {
        logic [1:0] ch;
        logic       rf;
        logic       gn;
    } conv_exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rd_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       conv_start;
    logic [1:0] conv_chan;
    logic       conv_ref;
    logic       conv_gain;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = 10'h000;

    int checks = 0;
    int fails = 0;
    int n_starts = 0;
    int busy_cnt = 0;
    int pkt_k = 0;
    int cyc = 0;
    int snap;

    logic [7:0] exp_q[$];
    conv_exp_t  conv_q[$];

    adcseq_top uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_req(rd_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_ref(conv_ref),
        .conv_gain(conv_gain), .conv_done(conv_done), .conv_result(conv_result)
    );

    always #5 clk = ~clk;

    function automatic logic [9:0] res_of(int k);
        return 10'((k * 193 + 45) % 1024);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endfunction

    // converter model: answers each start after LAT cycles and checks the request
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (rst) begin
            busy_cnt = 0;
        end else if (conv_start) begin
            chk(busy_cnt == 0, "R4", "start while busy", busy_cnt, 0);
            if (conv_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected conversion on input", conv_chan, 3);
            end else begin
                conv_exp_t e;
                e = conv_q.pop_front();
                chk(conv_chan == e.ch, "R8 R11", "conversion input", conv_chan, e.ch);
                chk({conv_ref, conv_gain} == {e.rf, e.gn}, "R7", "ref/gain",
                    {conv_ref, conv_gain}, {e.rf, e.gn});
            end
            n_starts++;
            busy_cnt = LAT;
        end else if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) begin
                conv_done   = 1'b1;
                conv_result = res_of(n_starts - 1);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            report();
            $finish;
        end
    end

    task automatic send(input logic [7:0] b);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic push_conv(input logic [1:0] ch, input logic rf, input logic gn);
        conv_q.push_back({ch, rf, gn});
    endtask

    // R5 R6: data bytes built from the requirement layouts
    task automatic push_pkt(input logic [1:0] ch);
        logic [9:0] r;
        r = res_of(pkt_k);
        pkt_k++;
        exp_q.push_back({2'b10, ch, r[9:6]});
        exp_q.push_back({1'b0, r[5:0], 1'b0});
    endtask

    task automatic rd(input string req);
        int t;
        logic [7:0] e;
        t = 0;
        while (!tx_valid && t < 2000) begin
            @(negedge clk);
            t++;
        end
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        if (!tx_valid) begin
            chk(1'b0, req, "no byte offered", 0, e);
        end else begin
            chk(tx_byte === e, req, "tx byte", tx_byte, e);
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
        end
    endtask

    task automatic rd_n(input int n, input string req);
        for (int i = 0; i < n; i++) rd(req);
    endtask

    task automatic quiet(input int n, input string req);
        snap = n_starts;
        repeat (n) @(negedge clk);
        chk(n_starts == snap, req, "starts while quiet", n_starts, snap);
        chk(tx_valid == 1'b0, req, "tx_valid while quiet", tx_valid, 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1
        chk(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
        chk(conv_start == 1'b0, "R1", "conv_start after reset", conv_start, 0);
        quiet(40, "R1");

        // R2: wrong prefix, unused input field (with burst bit clear), wrong prefix
        send(8'h40);
        send(8'hF0);
        send(8'hB5);
        quiet(60, "R2");

        // R3: demand on input 0, echo visible in the following cycle
        push_conv(2'd0, 1'b0, 1'b0);
        send(8'hC2);
        chk(tx_valid && tx_byte == 8'hC2, "R3", "immediate echo", tx_byte, 8'hC2);
        exp_q.push_back(8'hC2);
        push_pkt(2'd0);
        rd_n(3, "R3 R5 R6");

        // R7: per-input selections
        push_conv(2'd1, 1'b1, 1'b0);
        send(8'hDA);
        exp_q.push_back(8'hDA);
        push_pkt(2'd1);
        rd_n(3, "R7");
        push_conv(2'd2, 1'b0, 1'b1);
        send(8'hE3);
        exp_q.push_back(8'hE3);
        push_pkt(2'd2);
        rd_n(3, "R7");
        quiet(100, "R10");

        // R6: echo of a newer command must not split a result
        push_conv(2'd1, 1'b0, 1'b1);
        push_conv(2'd2, 1'b0, 1'b1);
        send(8'hD3);
        exp_q.push_back(8'hD3);
        push_pkt(2'd1);
        rd_n(2, "R6");
        send(8'hE3);
        chk(tx_valid && tx_byte[7] == 1'b0, "R6", "second byte kept ahead of echo",
            tx_byte, 0);
        rd(("R6"));
        exp_q.push_back(8'hE3);
        push_pkt(2'd2);
        rd_n(3, "R6 R12");
        quiet(50, "R10");

        // R8: burst on 1, then 2 added while 1 is converting
        push_conv(2'd1, 1'b1, 1'b0);
        push_conv(2'd1, 1'b1, 1'b0);
        push_conv(2'd2, 1'b0, 1'b1);
        push_conv(2'd1, 1'b1, 1'b0);
        push_conv(2'd2, 1'b0, 1'b1);
        push_conv(2'd1, 1'b1, 1'b0);
        send(8'hD8);
        exp_q.push_back(8'hD8);
        push_pkt(2'd1);
        rd_n(3, "R8");
        repeat (5) @(negedge clk);
        send(8'hE1);
        exp_q.push_back(8'hE1);
        push_pkt(2'd1);
        push_pkt(2'd2);
        push_pkt(2'd1);
        push_pkt(2'd2);
        rd_n(9, "R8 R12");

        // R9: no reads, the stream stalls after one buffered result
        repeat (5) @(negedge clk);
        snap = n_starts;
        repeat (200) @(negedge clk);
        chk(n_starts == snap, "R9", "starts without reads", n_starts, snap);
        chk(tx_valid && tx_byte[7:6] == 2'b10, "R9", "buffered first byte", tx_byte, 8'h90);

        // R11 R12: input 2 back to demand; its request beats the rotation
        push_conv(2'd2, 1'b0, 1'b0);
        push_conv(2'd1, 1'b1, 1'b0);
        push_conv(2'd1, 1'b1, 1'b0);
        send(8'hE2);
        chk(tx_valid && tx_byte == 8'hE2, "R12", "echo ahead of buffered data", tx_byte, 8'hE2);
        exp_q.push_back(8'hE2);
        push_pkt(2'd1);
        push_pkt(2'd2);
        push_pkt(2'd1);
        rd_n(7, "R11");

        // R10: last burst input back to demand, then silence
        repeat (5) @(negedge clk);
        push_conv(2'd1, 1'b1, 1'b0);
        send(8'hDA);
        exp_q.push_back(8'hDA);
        push_pkt(2'd1);
        push_pkt(2'd1);
        rd_n(5, "R11");
        quiet(150, "R10");
        chk(conv_q.size() == 0, "R10", "conversions left unseen", conv_q.size(), 0);
        chk(exp_q.size() == 0, "R10", "bytes left unread", exp_q.size(), 0);

        report();
        $finish;
    end

endmodule